// File: doc/BRIEF.md
# Multi-Lane Compliance Pattern Generator

This block produces the transmitter compliance test pattern for a serial link of several lanes, ahead of the 8b/10b encoder. Each lane carries a byte and a control flag per clock, in the parallel transmit form that a PHY interface expects. Every lane runs the same four-symbol loop: a comma, a data symbol, a comma, and a second data symbol.

A rotating group of lanes is shifted two symbols against the rest. This puts neighbouring lanes out of step so that crosstalk between them is exercised. The group is every lane whose index, taken modulo eight, equals a three-bit offset. The offset moves on by one after each pass of a parameterised number of loops, and it wraps from seven to zero.

The link state machine raises `enable` while the link sits in its compliance substate. When `enable` falls, all outputs go to zero. When it rises again, the pattern starts over from its first symbol with the offset at zero.

Top module: `compliance_pattern_gen`

## Requirements
- R1: While `rst_n` is low, every lane outputs data 0x00 with the K flag at 0.
- R2: Symbol encoding: the comma (K28.5) is data 0xBC with K=1, D21.5 is 0xB5 with K=0, and D10.2 is 0x4A with K=0. No other value ever carries K=1.
- R3: Counting the k-th clock edge at which `enable` is sampled high since it rose, with k starting at 0, a lane outside the shifted group outputs symbol k mod 4 of the sequence 0xBC, 0xB5, 0xBC, 0x4A. The output is registered and is visible after that edge.
- R4: A lane in the shifted group (lane index mod 8 equals the current offset) outputs symbol (k+2) mod 4, which gives 0xBC, 0x4A, 0xBC, 0xB5.
- R5: The offset is floor(k / (4*REPS_PER_PASS)) mod 8. It starts at 0, steps by one after each pass of REPS_PER_PASS four-symbol loops, and wraps from 7 to 0.
- R6: An edge at which `enable` is sampled low drives every lane to 0x00 with K=0. The next enabled edge restarts at k=0 with the offset at 0.
- R7: At every clock, the K flags of all lanes are either all 1 or all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the link is in its compliance substate |
| tx_data | output | 8*LANES | Per-lane symbol byte; lane n occupies bits [8n+7:8n] |
| tx_is_k | output | LANES | Per-lane control-symbol flag; bit n belongs to lane n |

## Verification
The bench runs long enough for the offset to wrap twice past seven with twelve lanes. This lets it see lanes 8 to 11 join the shifted group together with lanes 0 to 3. A design that used the plain lane index in place of its value modulo eight would leave those upper lanes unshifted. A design that stepped the offset one loop early or late would shift the wrong lanes on the cycles around each pass boundary. The bench also drops `enable` for a single cycle in the middle of a pass. A design that did not clear its loop or offset state on that cycle would come back mid-sequence or with a stale shifted group.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

  localparam logic [7:0] SYM_COMMA = 8'hBC;  // K28.5
  localparam logic [7:0] SYM_D21_5 = 8'hB5;
  localparam logic [7:0] SYM_D10_2 = 8'h4A;
  localparam int unsigned GROUP_SPAN = 8;     // shifted lane every eighth lane
  localparam int unsigned LOOP_LEN   = 4;     // symbols per pattern loop
  localparam int unsigned SHIFT_SYMS = 2;     // symbols of shift on a group lane

  typedef struct packed {
    logic [7:0] data;
    logic       is_k;
  } symbol_t;

  // Symbol for a position in the four-symbol loop.
  function automatic symbol_t loop_symbol(input logic [1:0] pos);
    symbol_t s;
    case (pos)
      2'd0, 2'd2: begin s.data = SYM_COMMA; s.is_k = 1'b1; end
      2'd1:       begin s.data = SYM_D21_5; s.is_k = 1'b0; end
      default:    begin s.data = SYM_D10_2; s.is_k = 1'b0; end
    endcase
    return s;
  endfunction

  // Loop position a lane reads, given the shared phase and whether it is shifted.
  function automatic logic [1:0] lane_position(input logic [1:0] phase, input logic shifted);
    return shifted ? (phase + 2'(SHIFT_SYMS)) : phase;
  endfunction

  // Lane belongs to the shifted group when its index mod 8 equals the offset.
  function automatic logic in_group(input int unsigned lane, input logic [2:0] offset);
    logic [2:0] low_bits;
    low_bits = 3'(lane % GROUP_SPAN);
    return low_bits == offset;
  endfunction

endpackage

// File: rtl/cpg_sequencer.sv
module cpg_sequencer #(
  parameter int unsigned REPS_PER_PASS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  output logic [1:0] phase,
  output logic [2:0] offset,
  output logic       loop_end,
  output logic       pass_end
);
  import cpg_pkg::*;

  localparam int unsigned REP_W    = (REPS_PER_PASS > 1) ? $clog2(REPS_PER_PASS) : 1;
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS_PER_PASS - 1);

  logic [REP_W-1:0] rep_q;

  // Named events for the assertions and for the lane logic.
  assign loop_end = enable && (phase == 2'(LOOP_LEN - 1));
  assign pass_end = loop_end && (rep_q == REP_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      rep_q  <= '0;
      offset <= '0;
    end else if (!enable) begin
      phase  <= '0;
      rep_q  <= '0;
      offset <= '0;
    end else begin
      phase <= phase + 2'd1;
      if (pass_end) begin
        rep_q  <= '0;
        offset <= offset + 3'd1;
      end else if (loop_end) begin
        rep_q <= rep_q + REP_W'(1);
      end
    end
  end

  // R5: offset only moves at the end of a pass
  p_offset_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !pass_end) |=> (offset == $past(offset)));

  // R5: at a pass end the offset steps by one, wrapping 7 -> 0
  p_offset_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pass_end |=> (offset == 3'($past(offset) + 3'd1)));

  // R6: a disabled cycle restarts the loop and the group
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (phase == 2'd0 && offset == 3'd0));

endmodule

// File: rtl/cpg_lane.sv
module cpg_lane #(
  parameter int unsigned LANE_ID = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [1:0] phase,
  input  logic [2:0] offset,
  output logic [7:0] data,
  output logic       is_k
);
  import cpg_pkg::*;

  logic       shifted;
  logic [1:0] pos;
  symbol_t    next_sym;

  assign shifted  = in_group(LANE_ID, offset);
  assign pos      = lane_position(phase, shifted);
  assign next_sym = loop_symbol(pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      is_k <= 1'b0;
    end else if (!enable) begin
      data <= '0;
      is_k <= 1'b0;
    end else begin
      data <= next_sym.data;
      is_k <= next_sym.is_k;
    end
  end

  // R6: a disabled edge leaves the lane at zero
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (data == 8'h00 && !is_k));

  // R2: only the comma byte ever carries the control flag
  p_k_only_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_k |-> (data == SYM_COMMA));

  // R3: two enabled edges in a row never give two commas in a row
  p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && is_k) |=> !is_k);

endmodule

// File: rtl/compliance_pattern_gen.sv
module compliance_pattern_gen #(
  parameter int unsigned LANES         = 12,
  parameter int unsigned REPS_PER_PASS = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  output logic [8*LANES-1:0] tx_data,
  output logic [LANES-1:0]   tx_is_k
);

  logic [1:0] phase;
  logic [2:0] offset;
  logic       loop_end;
  logic       pass_end;

  cpg_sequencer #(
    .REPS_PER_PASS(REPS_PER_PASS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .phase    (phase),
    .offset   (offset),
    .loop_end (loop_end),
    .pass_end (pass_end)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cpg_lane #(
      .LANE_ID(g)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .phase  (phase),
      .offset (offset),
      .data   (tx_data[8*g +: 8]),
      .is_k   (tx_is_k[g])
    );
  end

  // R7: the control flags of all lanes move together
  p_k_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_is_k == '0) || (tx_is_k == '1));

  // R1: reset leaves every lane silent
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (tx_is_k == '0 || $isunknown(tx_is_k));
    end
  end

endmodule

// File: tb/test_compliance_pattern_gen.sv
module test_compliance_pattern_gen;
  localparam int LANES = 12;
  localparam int REPS  = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b0;
  logic [8*LANES-1:0] tx_data;
  logic [LANES-1:0]   tx_is_k;

  compliance_pattern_gen #(.LANES(LANES), .REPS_PER_PASS(REPS)) i_compliance_pattern_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tx_data(tx_data), .tx_is_k(tx_is_k)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int k = 0;
  logic en_s = 1'b0;
  logic rst_s = 1'b0;

  task automatic check(input string tag, input int lane, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s lane %0d cycle %0d: got data=%h k=%b, expected data=%h k=%b",
               tag, lane, cycles, got[8:1], got[0], exp[8:1], exp[0]);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Inputs as seen by the design at each rising edge.
  always @(posedge clk) begin
    en_s  <= enable;
    rst_s <= rst_n;
  end

  // Reference model: compare after each rising edge.
  always @(negedge clk) begin
    int off;
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: run did not end, cycle %0d expected below 5000", cycles);
      summary();
    end
    if (!rst_s || !en_s) begin
      for (int l = 0; l < LANES; l++)
        check(!rst_s ? "R1" : "R6", l, {tx_data[8*l +: 8], tx_is_k[l]}, 9'h000);
      k = 0;
    end else begin
      off = (k / (4 * REPS)) % 8;
      for (int l = 0; l < LANES; l++) begin
        bit grp;
        int pos;
        logic [8:0] exp;
        string tag;
        grp = ((l % 8) == off);
        pos = grp ? (k + 2) % 4 : k % 4;
        case (pos)
          0, 2: exp = {8'hBC, 1'b1};
          1:    exp = {8'hB5, 1'b0};
          default: exp = {8'h4A, 1'b0};
        endcase
        if (grp) tag = (off != 0) ? "R5" : "R4";
        else tag = "R3";
        check(tag, l, {tx_data[8*l +: 8], tx_is_k[l]}, exp);
      end
      // R2: literal encoding on an unshifted lane
      if (off != 7) begin
        case (k % 4)
          0, 2: check("R2", 7, {tx_data[63:56], tx_is_k[7]}, 9'h179);
          1:    check("R2", 7, {tx_data[63:56], tx_is_k[7]}, 9'h16A);
          default: check("R2", 7, {tx_data[63:56], tx_is_k[7]}, 9'h094);
        endcase
      end
      k++;
    end
    // R7: all flags equal
    checks++;
    if (!(tx_is_k == '0 || tx_is_k == '1)) begin
      errors++;
      $display("FAIL R7 cycle %0d: got k flags %b, expected all equal", cycles, tx_is_k);
    end
  end

  task automatic run(input logic en, input int n);
    @(negedge clk); #1 enable = en;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    run(1'b0, 3);    // R6 idle after reset
    run(1'b1, 150);  // R3 R4 R5: two offset wraps
    run(1'b0, 3);    // R6
    run(1'b1, 11);   // R6 restart mid-pass
    run(1'b0, 1);    // one-cycle drop
    run(1'b1, 70);
    run(1'b0, 2);
    repeat (2) @(negedge clk);
    #1 summary();
  end

endmodule